// File: doc/BRIEF.md
# Split Binary Capture Sequencer Counter

This block is a wide synchronous binary counter that paces a capture run. A short, fast low section counts every running cycle. A wide high section advances only when the low section wraps. The long carry chain of the high section therefore gets a whole low-section period to settle, and it stays off the critical path at a high sample clock.

The high section does not use a combinational carry. It uses a registered step enable, which is decoded when the low section is one state short of all-ones. The joined value is still an exact binary count with no lag between the halves. The same count can therefore drive address and refresh sequencing. The most significant bit is the completion flag, and it also stops all further counting.

A set of registered one-hot phase strobes follows the low section. These strobes pace word assembly and short memory bursts. A synchronous start input clears the block for a new run. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `split_cnt`

## Requirements
- R1: While reset is asserted, and on the cycle after start_i, count_o is 0, done_o is 0 and phase_o equals 1 (bit 0 set).
- R2: On each clock edge where run_i is 1, start_i is 0 and done_o is 0, count_o increases by exactly 1 as a plain binary value.
- R3: The high part of count_o (bits above the LO_W low bits) changes only on the edge where the low part goes from all-ones to zero, and it increments on that same edge. The low part never shows a stale high part, even when run_i pauses at the low values all-ones minus one or all-ones.
- R4: On an edge where run_i is 0 and start_i is 0, count_o and phase_o keep their values.
- R5: done_o equals the most significant bit of count_o. From a cleared state, it rises after exactly 2^(LO_W+HI_W-1) running edges.
- R6: While done_o is 1, count_o, phase_o and done_o stay fixed whatever run_i does, until start_i or reset.
- R7: phase_o has exactly one bit set, and that bit is the one whose index equals the low LO_W bits of count_o.
- R8: start_i takes priority over run_i. A start with run_i high still leaves count_o at 0 on the next cycle.
- R9: After rst_n rises, the block stays cleared for two clock edges even with run_i high. The first increment comes on the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Synchronous clear that begins a new run |
| run_i | input | 1 | Count enable |
| count_o | output | LO_W+HI_W | Full binary count |
| done_o | output | 1 | Run complete, the top bit of the count |
| phase_o | output | 2^LO_W | One-hot low-section phase strobes |

## Verification
On every cycle, the assertions check the following: the single-step increment, holding while paused, freezing after completion, the high half moving only at a low wrap, the clearing effect of start, and the one-hot phase pointing at the low count bits. Only the bench scenarios can show that completion comes after exactly the full half-range of running edges, that pauses at the two states before the wrap do not lose or duplicate a high-section step, and that the reset synchronizer adds the expected two-edge delay. The bench sweeps a reduced 3-plus-5-bit configuration over full runs, with a running reference count.

// File: rtl/split_cnt_pkg.sv
package split_cnt_pkg;
  localparam int LO_W_DEF = 3;
  localparam int HI_W_DEF = 19;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = split_cnt_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cnt_lo_sec.sv
module cnt_lo_sec #(
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [LO_W-1:0] lo_o,
  output logic            step_en_o
);
  // enable is decoded one state before all-ones, so it is registered in time
  localparam logic [LO_W-1:0] PRE_WRAP = LO_W'((1 << LO_W) - 2);

  logic [LO_W-1:0] lo_q, lo_d;
  logic            en_q, en_d;

  always_comb begin
    lo_d = lo_q;
    en_d = en_q;
    if (clr_i) begin
      lo_d = '0;
      en_d = 1'b0;
    end else if (adv_i) begin
      lo_d = lo_q + 1'b1;
      en_d = (lo_q == PRE_WRAP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      en_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
      en_q <= en_d;
    end
  end

  assign lo_o      = lo_q;
  assign step_en_o = en_q;
endmodule

// File: rtl/cnt_hi_sec.sv
module cnt_hi_sec #(
  parameter int HI_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  output logic [HI_W-1:0] hi_o
);
  logic [HI_W-1:0] hi_q, hi_d;

  always_comb begin
    hi_d = hi_q;
    if (clr_i)       hi_d = '0;
    else if (step_i) hi_d = hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign hi_o = hi_q;
endmodule

// File: rtl/phase_dec.sv
module phase_dec #(
  parameter int LO_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  adv_i,
  output logic [(1<<LO_W)-1:0]  phase_o
);
  localparam int N = 1 << LO_W;

  logic [N-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr_i)      ph_d = N'(1);
    else if (adv_i) ph_d = {ph_q[N-2:0], ph_q[N-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= N'(1);
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/split_cnt.sv
module split_cnt #(
  parameter int LO_W = split_cnt_pkg::LO_W_DEF,
  parameter int HI_W = split_cnt_pkg::HI_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     run_i,
  output logic [LO_W+HI_W-1:0]     count_o,
  output logic                     done_o,
  output logic [(1<<LO_W)-1:0]     phase_o
);
  localparam int CNT_W = LO_W + HI_W;

  logic            srst_n;
  logic [LO_W-1:0] lo;
  logic [HI_W-1:0] hi;
  logic            step_en;
  logic            adv;
  logic            hi_step;

  rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // the top bit stops the whole counter
  assign done_o  = hi[HI_W-1];
  assign adv     = run_i & ~done_o;
  assign hi_step = adv & step_en;

  cnt_lo_sec #(.LO_W(LO_W)) u_lo (
    .clk       (clk),
    .rst_n     (srst_n),
    .clr_i     (start_i),
    .adv_i     (adv),
    .lo_o      (lo),
    .step_en_o (step_en)
  );

  cnt_hi_sec #(.HI_W(HI_W)) u_hi (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr_i  (start_i),
    .step_i (hi_step),
    .hi_o   (hi)
  );

  phase_dec #(.LO_W(LO_W)) u_phase (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr_i   (start_i),
    .adv_i   (adv),
    .phase_o (phase_o)
  );

  assign count_o = CNT_W'({hi, lo});
endmodule

// File: rtl/split_cnt_chk.sv
module split_cnt_chk #(
  parameter int LO_W = 3,
  parameter int HI_W = 19
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     run_i,
  input logic [LO_W+HI_W-1:0]     count_o,
  input logic                     done_o,
  input logic [(1<<LO_W)-1:0]     phase_o
);
  localparam int CNT_W = LO_W + HI_W;

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && !done_o) |=> count_o == CNT_W'($past(count_o) + 1'b1));

  // R3
  hi_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && count_o[LO_W-1:0] != '1) |=> count_o[CNT_W-1:LO_W] == $past(count_o[CNT_W-1:LO_W]));

  // R4
  hold_when_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !start_i) |=> $stable(count_o) && $stable(phase_o));

  // R6
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o && $stable(count_o) && $stable(phase_o));

  // R5
  done_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> count_o[CNT_W-2:0] == '0);

  // R7
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_o) == 1 && phase_o[count_o[LO_W-1:0]]);

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> count_o == '0 && !done_o);
endmodule

bind split_cnt split_cnt_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .start_i (start_i),
  .run_i   (run_i),
  .count_o (count_o),
  .done_o  (done_o),
  .phase_o (phase_o)
);

// File: tb/split_cnt_tb.sv
`timescale 1ns/1ps
module split_cnt_tb;
  localparam int LO_W = 3;
  localparam int HI_W = 5;
  localparam int CNT_W = LO_W + HI_W;
  localparam int HALF = 1 << (CNT_W - 1);
  localparam int PH_N = 1 << LO_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic run_i = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic done_o;
  logic [PH_N-1:0] phase_o;

  int checks = 0;
  int failures = 0;
  int ref_cnt = 0;
  int run_edges = 0;
  bit done_seen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  split_cnt #(.LO_W(LO_W), .HI_W(HI_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run_i),
    .count_o(count_o), .done_o(done_o), .phase_o(phase_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int prev_lo;
    chk(int'(count_o) == ref_cnt, tag, int'(count_o), ref_cnt);
    chk(done_o == (ref_cnt >= HALF), "R5", int'(done_o), int'(ref_cnt >= HALF));
    chk(int'(phase_o) == (1 << (ref_cnt % PH_N)), "R7", int'(phase_o), 1 << (ref_cnt % PH_N));
    prev_lo = ref_cnt % PH_N;
    if (prev_lo == 0)
      chk(int'(count_o) >> LO_W == ref_cnt >> LO_W, "R3", int'(count_o) >> LO_W, ref_cnt >> LO_W);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit run, input bit st);
    string tag;
    run_i = run;
    start_i = st;
    if (st) tag = "R8";
    else if (ref_cnt >= HALF) tag = "R6";
    else if (!run) tag = "R4";
    else tag = "R2";
    @(posedge clk);
    if (st) begin
      ref_cnt = 0;
      run_edges = 0;
      done_seen = 0;
    end else if (run && ref_cnt < HALF) begin
      ref_cnt++;
      run_edges++;
    end
    @(negedge clk);
    compare(tag);
    if (done_o && !done_seen) begin
      done_seen = 1;
      chk(run_edges == HALF, "R5", run_edges, HALF);
    end
  endtask

  initial begin
    run_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(count_o == '0, "R1", int'(count_o), 0);
    chk(done_o == 1'b0, "R1", int'(done_o), 0);
    chk(phase_o == PH_N'(1), "R1", int'(phase_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_o == '0, "R9", int'(count_o), 0);
    @(negedge clk);
    chk(count_o == '0, "R9", int'(count_o), 0);
    @(negedge clk);
    chk(int'(count_o) == 1, "R9", int'(count_o), 1);

    // fresh run, continuous counting to completion and beyond
    step(1'b0, 1'b1);
    chk(count_o == '0, "R1", int'(count_o), 0);
    for (int i = 0; i < HALF + 10; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) step(i[0], 1'b0);

    // start while run is high
    step(1'b1, 1'b1);

    // irregular pauses, including stalls before and at the wrap states
    for (int i = 0; i < 3 * HALF; i++) begin
      bit r;
      r = (i % 3) != 2;
      if ((ref_cnt % PH_N) >= PH_N - 2 && (i % 5) < 3) r = 1'b0;
      step(r, 1'b0);
    end
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
    chk(done_o == 1'b1, "R6", int'(done_o), 1);

    // reset mid-run then a short run
    step(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule